// File: doc/BRIEF.md
# Host-to-Card Memory Window Decoder

This block sits between a 24-bit host memory bus and one removable-card socket. Software programs a small byte-wide register file through an index/data pair: a write to the index port selects a register, and a later write to the data port stores a byte there. The registers hold an enable byte and, for each of five memory windows, a start page, a stop page and a card-offset page. Each page value is in 4 KB units. Further bits in those bytes set the data width, zero-wait-state request, wait-state count, write protection and attribute-memory steering of the window.

For every host memory cycle, the block checks the page address (A23..A12) against all enabled windows. The lowest-numbered matching window wins. The outputs are registered and appear one clock after the host cycle is sampled. They give the selected window, the 26-bit card address (host address plus the window offset), the attribute/common select, the width and wait-state settings, and read and write strobes. A write into a protected window produces no write strobe and raises a write-blocked flag instead. A separate 16-bit chip-select indication is computed with either fine or coarse address granularity, chosen by a mode bit.

The parameter `SOCKET` places the block's 64 registers in the index space: socket 0 uses 00h..3Fh and socket 1 uses 40h..7Fh.

Top module: `sockwin_decoder`

## Requirements
- R1: After reset every register reads back 00h and no host cycle hits any window.
- R2: An index-port write latches the full 8-bit index. A data-port write stores the byte at register `index[5:0]` only when `index[7:6]` equals `SOCKET`; otherwise it is ignored. `cfg_rdata` shows the selected register, or 00h when the index belongs to another socket. All bits read back as written, including bits that have no function.
- R3: The enable register is at local index 06h, and bit n (n = 0..4) enables window n. Window n occupies local indexes 10h+8n onward:
  - +0 holds start A19..A12, and bits 3..0 of +1 hold start A23..A20;
  - +2 holds stop A19..A12, and bits 3..0 of +3 hold stop A23..A20;
  - +4 holds offset bits 7..0, and bits 5..0 of +5 hold offset bits 13..8.

  A cycle hits window n when that window is enabled and start <= A23..A12 <= stop.
- R4: When several windows hit, `card_win` reports the lowest-numbered one, and all outputs take their values from that window.
- R5: On a hit, `card_addr` = (host address + offset*4096) mod 2^26, so the low 12 bits pass through. On a miss, `card_addr` is 0.
- R6: On a hit, the outputs come from the window's registers. `card_wide` is start-high bit 7, `card_zero_ws` is start-high bit 6, `card_ws` is stop-high bits 7..6 and `card_attr` is offset-high bit 6. Start-high bits 5..4 have no effect. On a miss, all of these outputs are 0.
- R7: `card_cs16` is 1 when some enabled window with start-high bit 7 set matches the address. When enable bit 5 is 1 (fine mode), the match uses A23..A12 against start and stop. When enable bit 5 is 0 (coarse mode), the match compares A23..A17 against start[11:5] and stop[11:5].
- R8: Offset-high bit 7 write-protects a window. A write that hits a protected window gives `card_we`=0 and `wr_blocked`=1. A read of that window gives `card_re`=1. Unprotected write hits give `card_we`=1.
- R9: Outputs are registered and reflect the host cycle sampled at the previous clock edge. When `host_valid` was 0, every output except `cfg_rdata` is 0.
- R10: Enable bits 7..6 (the I/O window enables) are stored but have no effect on memory decoding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| idx_we | input | 1 | Write `cfg_wdata` into the index latch |
| dat_we | input | 1 | Write `cfg_wdata` into the indexed register |
| cfg_wdata | input | 8 | Configuration write byte |
| cfg_rdata | output | 8 | Byte of the indexed register |
| host_valid | input | 1 | Host memory cycle present |
| host_we | input | 1 | Host cycle is a write |
| host_addr | input | 24 | Host byte address |
| card_hit | output | 1 | Cycle hit an enabled window |
| card_win | output | 3 | Number of the selected window |
| card_addr | output | 26 | Translated card address |
| card_attr | output | 1 | Attribute memory (1) or common memory (0) |
| card_cs16 | output | 1 | 16-bit chip-select indication |
| card_wide | output | 1 | 16-bit data bus for this cycle |
| card_zero_ws | output | 1 | Zero wait states requested |
| card_ws | output | 2 | Wait-state count |
| card_we | output | 1 | Card write strobe |
| card_re | output | 1 | Card read strobe |
| wr_blocked | output | 1 | Write suppressed by protection |

## Verification
A corrupted register byte shows on `cfg_rdata` as soon as the index points at it. It also shows on the decode outputs in the clock after any host cycle that lands in the affected window, as a wrong hit, address or attribute. A fault in the priority or hit logic shows one cycle after a cycle that lands in overlapping windows or on a start or stop page, as a wrong `card_win` or `card_addr`. A fault in protection or in the chip-select mode shows in that same next cycle, on `wr_blocked`, `card_we` or `card_cs16`. The reference model is compared on every clock, so any of these faults is reported at the first cycle that exposes it.

// File: rtl/sockwin_pkg.sv
package sockwin_pkg;
    localparam int HADDR_W    = 24;
    localparam int CADDR_W    = 26;
    localparam int PAGE_W     = 12;
    localparam int PAGE_BITS  = HADDR_W - PAGE_W;
    localparam int OFF_W      = CADDR_W - PAGE_W;
    localparam int REG_NUM    = 64;
    localparam int IDX_W      = $clog2(REG_NUM);
    localparam int ENA_IDX    = 6;
    localparam int WIN_BASE   = 16;
    localparam int WIN_STRIDE = 8;
    localparam int COARSE_LSB = 5;

    typedef logic [7:0] byte_t;
    typedef byte_t [REG_NUM-1:0] regfile_t;

    typedef struct packed {
        logic [PAGE_BITS-1:0] start;
        logic [PAGE_BITS-1:0] stop;
        logic [OFF_W-1:0]     offset;
        logic                 wide;
        logic                 zws;
        logic [1:0]           ws;
        logic                 wp;
        logic                 attr;
    } win_cfg_t;

    function automatic win_cfg_t get_win(input regfile_t r, input int n);
        win_cfg_t c;
        int base;
        base     = WIN_BASE + WIN_STRIDE * n;
        c.start  = {r[base+1][3:0], r[base]};
        c.stop   = {r[base+3][3:0], r[base+2]};
        c.offset = {r[base+5][5:0], r[base+4]};
        c.wide   = r[base+1][7];
        c.zws    = r[base+1][6];
        c.ws     = r[base+3][7:6];
        c.wp     = r[base+5][7];
        c.attr   = r[base+5][6];
        return c;
    endfunction
endpackage

// File: rtl/sockwin_regs.sv
module sockwin_regs
    import sockwin_pkg::*;
#(
    parameter logic [1:0] SOCKET = 2'd0
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     idx_we,
    input  logic     dat_we,
    input  byte_t    wdata,
    output byte_t    rdata,
    output regfile_t regs
);
    typedef struct packed {
        byte_t    idx;
        regfile_t regs;
    } st_t;

    st_t              st_d, st_q;
    logic             own;
    logic [IDX_W-1:0] local_idx;

    assign own       = (st_q.idx[7:6] == SOCKET);
    assign local_idx = st_q.idx[IDX_W-1:0];

    always_comb begin
        st_d = st_q;
        if (dat_we && own) begin
            st_d.regs[local_idx] = wdata;
        end
        if (idx_we) begin
            st_d.idx = wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rdata = own ? st_q.regs[local_idx] : 8'h00;
    assign regs  = st_q.regs;
endmodule

// File: rtl/sockwin_match.sv
module sockwin_match
    import sockwin_pkg::*;
(
    input  win_cfg_t             cfg,
    input  logic                 en,
    input  logic                 fine,
    input  logic [PAGE_BITS-1:0] page,
    output logic                 hit,
    output logic                 hit16
);
    logic coarse_hit;
    logic unused_cfg;

    assign hit = en && (page >= cfg.start) && (page <= cfg.stop);

    assign coarse_hit = en
        && (page[PAGE_BITS-1:COARSE_LSB] >= cfg.start[PAGE_BITS-1:COARSE_LSB])
        && (page[PAGE_BITS-1:COARSE_LSB] <= cfg.stop[PAGE_BITS-1:COARSE_LSB]);

    assign hit16 = cfg.wide && (fine ? hit : coarse_hit);

    assign unused_cfg = ^cfg;
endmodule

// File: rtl/sockwin_decoder.sv
module sockwin_decoder
    import sockwin_pkg::*;
#(
    parameter logic [1:0] SOCKET  = 2'd0,
    parameter int         NUM_WIN = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               idx_we,
    input  logic               dat_we,
    input  logic [7:0]         cfg_wdata,
    output logic [7:0]         cfg_rdata,
    input  logic               host_valid,
    input  logic               host_we,
    input  logic [23:0]        host_addr,
    output logic               card_hit,
    output logic [2:0]         card_win,
    output logic [25:0]        card_addr,
    output logic               card_attr,
    output logic               card_cs16,
    output logic               card_wide,
    output logic               card_zero_ws,
    output logic [1:0]         card_ws,
    output logic               card_we,
    output logic               card_re,
    output logic               wr_blocked
);
    localparam int WIN_IDX_W = 3;

    typedef struct packed {
        logic                 hit;
        logic [WIN_IDX_W-1:0] win;
        logic [CADDR_W-1:0]   addr;
        logic                 attr;
        logic                 cs16;
        logic                 wide;
        logic                 zws;
        logic [1:0]           ws;
        logic                 we;
        logic                 re;
        logic                 blk;
    } out_t;

    regfile_t             regs;
    byte_t                ena;
    logic                 fine;
    win_cfg_t             cfg [NUM_WIN];
    logic [NUM_WIN-1:0]   hits;
    logic [NUM_WIN-1:0]   hits16;
    logic [WIN_IDX_W-1:0] sel;
    out_t                 o_d, o_q;
    logic                 unused_regs;

    sockwin_regs #(.SOCKET(SOCKET)) i_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .idx_we(idx_we),
        .dat_we(dat_we),
        .wdata (cfg_wdata),
        .rdata (cfg_rdata),
        .regs  (regs)
    );

    assign ena         = regs[ENA_IDX];
    assign fine        = ena[5];
    assign unused_regs = ^regs;

    for (genvar g = 0; g < NUM_WIN; g++) begin : g_win
        assign cfg[g] = get_win(regs, g);
        sockwin_match i_match (
            .cfg  (cfg[g]),
            .en   (ena[g]),
            .fine (fine),
            .page (host_addr[HADDR_W-1:PAGE_W]),
            .hit  (hits[g]),
            .hit16(hits16[g])
        );
    end

    always_comb begin
        o_d = '0;
        sel = '0;
        for (int i = NUM_WIN - 1; i >= 0; i--) begin
            if (hits[i]) begin
                sel = WIN_IDX_W'(i);
            end
        end
        if (host_valid) begin
            o_d.cs16 = |hits16;
            if (|hits) begin
                o_d.hit  = 1'b1;
                o_d.win  = sel;
                o_d.addr = CADDR_W'(host_addr) + {cfg[sel].offset, {PAGE_W{1'b0}}};
                o_d.attr = cfg[sel].attr;
                o_d.wide = cfg[sel].wide;
                o_d.zws  = cfg[sel].zws;
                o_d.ws   = cfg[sel].ws;
                o_d.we   = host_we && !cfg[sel].wp;
                o_d.blk  = host_we && cfg[sel].wp;
                o_d.re   = !host_we;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            o_q <= '0;
        end else begin
            o_q <= o_d;
        end
    end

    assign card_hit     = o_q.hit;
    assign card_win     = o_q.win;
    assign card_addr    = o_q.addr;
    assign card_attr    = o_q.attr;
    assign card_cs16    = o_q.cs16;
    assign card_wide    = o_q.wide;
    assign card_zero_ws = o_q.zws;
    assign card_ws      = o_q.ws;
    assign card_we      = o_q.we;
    assign card_re      = o_q.re;
    assign wr_blocked   = o_q.blk;
endmodule

// File: rtl/sockwin_checker.sv
module sockwin_checker #(
    parameter int NUM_WIN = 5
) (
    input logic        clk,
    input logic        rst_n,
    input logic        host_valid,
    input logic        host_we,
    input logic [23:0] host_addr,
    input logic        card_hit,
    input logic [2:0]  card_win,
    input logic [25:0] card_addr,
    input logic        card_attr,
    input logic        card_cs16,
    input logic        card_wide,
    input logic        card_zero_ws,
    input logic [1:0]  card_ws,
    input logic        card_we,
    input logic        card_re,
    input logic        wr_blocked
);
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!host_valid) |-> !card_hit && !card_cs16 && !card_we && !card_re && !wr_blocked); // R9

    AST_LOW_PAGE_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        card_hit |-> card_addr[11:0] == $past(host_addr[11:0])); // R5

    AST_MISS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !card_hit |-> card_addr == '0 && !card_attr && !card_wide && !card_zero_ws
                      && card_ws == '0 && !card_we && !card_re && card_win == '0); // R6

    AST_PROT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(card_we && wr_blocked)); // R8

    AST_BLOCK_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_blocked |-> card_hit && $past(host_valid && host_we)); // R8

    AST_READ_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        card_hit |-> card_re == !$past(host_we)); // R8

    AST_WIN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        card_hit |-> 32'(card_win) < NUM_WIN); // R4
endmodule

bind sockwin_decoder sockwin_checker #(.NUM_WIN(NUM_WIN)) i_sockwin_checker (.*);

// File: tb/test_sockwin_decoder.sv
module test_sockwin_decoder;
    localparam int         CLK_PERIOD = 10;
    localparam logic [1:0] SOCK       = 2'd1;
    localparam logic [1:0] OTHER      = 2'd0;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        idx_we = 1'b0, dat_we = 1'b0;
    logic [7:0]  cfg_wdata = '0;
    logic [7:0]  cfg_rdata;
    logic        host_valid = 1'b0, host_we = 1'b0;
    logic [23:0] host_addr = '0;
    logic        card_hit, card_attr, card_cs16, card_wide, card_zero_ws;
    logic        card_we, card_re, wr_blocked;
    logic [2:0]  card_win;
    logic [25:0] card_addr;
    logic [1:0]  card_ws;

    int n_checks = 0;
    int n_errors = 0;

    sockwin_decoder #(.SOCKET(SOCK)) i_sockwin_decoder (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string what, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual %0h expected %0h", what, act, exp);
        end
    endtask

    // Behavioural reference model
    logic [7:0]  mregs [64];
    logic [7:0]  midx;
    logic        e_hit, e_attr, e_cs16, e_wide, e_zws, e_we, e_re, e_blk;
    logic [2:0]  e_win;
    logic [25:0] e_addr;
    logic [1:0]  e_ws;
    int          m_page, m_s, m_e, m_b, m_win, m_off;
    logic        m_cs;

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 64; i++) mregs[i] = 8'h00;
            midx = 8'h00;
            {e_hit, e_attr, e_cs16, e_wide, e_zws, e_we, e_re, e_blk} = '0;
            e_win = '0; e_addr = '0; e_ws = '0;
        end else begin
            {e_hit, e_attr, e_cs16, e_wide, e_zws, e_we, e_re, e_blk} = '0;
            e_win = '0; e_addr = '0; e_ws = '0;
            m_page = int'(host_addr) / 4096;
            m_win = -1;
            m_cs = 1'b0;
            for (int n = 0; n < 5; n++) begin
                m_b = 16 + 8 * n;
                m_s = (int'(mregs[m_b+1]) % 16) * 256 + int'(mregs[m_b]);
                m_e = (int'(mregs[m_b+3]) % 16) * 256 + int'(mregs[m_b+2]);
                if (mregs[6][n] && m_page >= m_s && m_page <= m_e && m_win < 0) m_win = n;
                if (mregs[6][n] && mregs[m_b+1][7]) begin
                    if (mregs[6][5])
                        m_cs = m_cs | (m_page >= m_s && m_page <= m_e);
                    else
                        m_cs = m_cs | (m_page / 32 >= m_s / 32 && m_page / 32 <= m_e / 32);
                end
            end
            if (host_valid) begin
                e_cs16 = m_cs;
                if (m_win >= 0) begin
                    m_b    = 16 + 8 * m_win;
                    m_off  = (int'(mregs[m_b+5]) % 64) * 256 + int'(mregs[m_b+4]);
                    e_hit  = 1'b1;
                    e_win  = 3'(m_win);
                    e_addr = 26'((longint'(host_addr) + longint'(m_off) * 4096) % (64'd1 << 26));
                    e_attr = mregs[m_b+5][6];
                    e_wide = mregs[m_b+1][7];
                    e_zws  = mregs[m_b+1][6];
                    e_ws   = mregs[m_b+3][7:6];
                    e_we   = host_we && !mregs[m_b+5][7];
                    e_blk  = host_we && mregs[m_b+5][7];
                    e_re   = !host_we;
                end
            end
            if (dat_we && midx[7:6] == SOCK) mregs[midx[5:0]] = cfg_wdata;
            if (idx_we) midx = cfg_wdata;
        end
    end

    always @(negedge clk) begin
        if (rst_n) begin
            check("R3 model card_hit", 32'(card_hit), 32'(e_hit));
            check("R4 model card_win", 32'(card_win), 32'(e_win));
            check("R5 model card_addr", 32'(card_addr), 32'(e_addr));
            check("R6 model card_attr", 32'(card_attr), 32'(e_attr));
            check("R6 model card_wide", 32'(card_wide), 32'(e_wide));
            check("R6 model card_zero_ws", 32'(card_zero_ws), 32'(e_zws));
            check("R6 model card_ws", 32'(card_ws), 32'(e_ws));
            check("R7 model card_cs16", 32'(card_cs16), 32'(e_cs16));
            check("R8 model card_we", 32'(card_we), 32'(e_we));
            check("R8 model wr_blocked", 32'(wr_blocked), 32'(e_blk));
            check("R8 model card_re", 32'(card_re), 32'(e_re));
            check("R2 model cfg_rdata", 32'(cfg_rdata),
                  32'((midx[7:6] == SOCK) ? mregs[midx[5:0]] : 8'h00));
        end
    end

    task automatic wr_reg(input logic [5:0] off, input logic [7:0] data, input logic [1:0] sock = SOCK);
        @(negedge clk); idx_we = 1'b1; cfg_wdata = {sock, off};
        @(negedge clk); idx_we = 1'b0; dat_we = 1'b1; cfg_wdata = data;
        @(negedge clk); dat_we = 1'b0;
    endtask

    task automatic set_idx(input logic [5:0] off, input logic [1:0] sock = SOCK);
        @(negedge clk); idx_we = 1'b1; cfg_wdata = {sock, off};
        @(negedge clk); idx_we = 1'b0;
    endtask

    task automatic prog_win(input int n, input logic [7:0] s_hi, s_lo, e_hi, e_lo, o_hi, o_lo);
        wr_reg(6'(16 + 8 * n), s_lo);
        wr_reg(6'(17 + 8 * n), s_hi);
        wr_reg(6'(18 + 8 * n), e_lo);
        wr_reg(6'(19 + 8 * n), e_hi);
        wr_reg(6'(20 + 8 * n), o_lo);
        wr_reg(6'(21 + 8 * n), o_hi);
    endtask

    task automatic host(input logic [23:0] a, input logic we);
        @(negedge clk); host_valid = 1'b1; host_addr = a; host_we = we;
        @(negedge clk); host_valid = 1'b0; host_we = 1'b0;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        n_checks++; n_errors++;
        $display("FAIL watchdog (all requirements): actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        logic [31:0] lcg;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        for (int i = 0; i < 64; i++) begin
            set_idx(6'(i));
            check("R1 reset register readback", 32'(cfg_rdata), 32'h0);
        end
        host(24'h012000, 1'b0);
        check("R1 no hit after reset", 32'(card_hit), 32'h0);

        // Window 0: pages 012..01F, offset 100h, wide, zero-ws, ws=2, scratch bits set
        prog_win(0, 8'hF0, 8'h12, 8'h80, 8'h1F, 8'h01, 8'h00);
        wr_reg(6'h06, 8'h21);
        host(24'h011FFF, 1'b0);
        check("R3 below start misses", 32'(card_hit), 32'h0);
        host(24'h012000, 1'b0);
        check("R3 start page hits", 32'(card_hit), 32'h1);
        check("R5 start page card_addr", 32'(card_addr), 32'h112000);
        check("R6 wide", 32'(card_wide), 32'h1);
        check("R6 zero ws", 32'(card_zero_ws), 32'h1);
        check("R6 ws count", 32'(card_ws), 32'h2);
        check("R7 fine cs16 inside wide window", 32'(card_cs16), 32'h1);
        host(24'h01FFFF, 1'b0);
        check("R3 stop page hits", 32'(card_hit), 32'h1);
        check("R5 stop page card_addr", 32'(card_addr), 32'h11FFFF);
        host(24'h020000, 1'b0);
        check("R3 above stop misses", 32'(card_hit), 32'h0);
        set_idx(6'h11);
        check("R2 scratch bits read back", 32'(cfg_rdata), 32'hF0);

        // Window 1: pages 018..030, protected, attribute memory, overlaps window 0
        prog_win(1, 8'h00, 8'h18, 8'h00, 8'h30, 8'hC0, 8'h00);
        wr_reg(6'h06, 8'h23);
        host(24'h01A000, 1'b0);
        check("R4 overlap picks window 0", 32'(card_win), 32'h0);
        check("R4 overlap address from window 0", 32'(card_addr), 32'h11A000);
        host(24'h025000, 1'b0);
        check("R4 window 1 alone", 32'(card_win), 32'h1);
        check("R6 attribute select", 32'(card_attr), 32'h1);
        check("R8 protected read proceeds", 32'(card_re), 32'h1);
        host(24'h025000, 1'b1);
        check("R8 protected write no strobe", 32'(card_we), 32'h0);
        check("R8 protected write blocked", 32'(wr_blocked), 32'h1);
        host(24'h01A000, 1'b1);
        check("R8 unprotected write strobe", 32'(card_we), 32'h1);
        check("R8 unprotected write not blocked", 32'(wr_blocked), 32'h0);

        // R7: chip-select granularity
        host(24'h001000, 1'b0);
        check("R7 fine mode outside range", 32'(card_cs16), 32'h0);
        wr_reg(6'h06, 8'h03);
        host(24'h001000, 1'b0);
        check("R7 coarse mode widens match", 32'(card_cs16), 32'h1);
        check("R7 coarse mode is not a hit", 32'(card_hit), 32'h0);
        host(24'h025000, 1'b0);
        check("R7 coarse mode other block", 32'(card_cs16), 32'h0);

        // Window 2: pages F00..FFF, offset 3FFFh wraps
        prog_win(2, 8'h0F, 8'h00, 8'h0F, 8'hFF, 8'h3F, 8'hFF);
        wr_reg(6'h06, 8'h27);
        host(24'hF80000, 1'b0);
        check("R5 offset wrap card_addr", 32'(card_addr), 32'hF7F000);
        check("R4 wrap window number", 32'(card_win), 32'h2);

        // R2: writes addressed to the other socket are ignored
        wr_reg(6'h06, 8'h00, OTHER);
        set_idx(6'h06);
        check("R2 foreign write ignored", 32'(cfg_rdata), 32'h27);
        set_idx(6'h06, OTHER);
        check("R2 foreign index reads zero", 32'(cfg_rdata), 32'h0);
        host(24'hF80000, 1'b0);
        check("R2 decode kept after foreign write", 32'(card_hit), 32'h1);

        // R10: I/O enables have no memory effect
        wr_reg(6'h06, 8'hC0);
        host(24'h012000, 1'b0);
        check("R10 I/O enables alone do not hit", 32'(card_hit), 32'h0);
        wr_reg(6'h06, 8'hC1);
        host(24'h012000, 1'b0);
        check("R10 I/O enables leave window 0 unchanged", 32'(card_addr), 32'h112000);

        // R9: idle cycle
        @(negedge clk);
        check("R9 idle outputs quiet", 32'(card_hit), 32'h0);
        check("R9 idle cs16 quiet", 32'(card_cs16), 32'h0);

        // Pseudo-random sweep against the model
        wr_reg(6'h06, 8'h27);
        lcg = 32'h1234_5678;
        for (int k = 0; k < 400; k++) begin
            lcg = lcg * 32'd1664525 + 32'd1013904223;
            @(negedge clk);
            host_valid = lcg[30];
            host_we    = lcg[29];
            host_addr  = {lcg[28] ? 4'hF : 4'h0, lcg[19:0]};
            if (k == 200) begin
                host_valid = 1'b0;
                wr_reg(6'h06, 8'h07);
            end
        end
        @(negedge clk); host_valid = 1'b0;
        repeat (2) @(negedge clk);

        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end
endmodule